// File: doc/BRIEF.md
# Sequential Memory Word Search Unit

This unit performs a multi-cycle search of a word-addressed memory for a key. One start pulse captures a key and a word-aligned start byte address. The unit then reads consecutive words from a single-port synchronous memory with one-cycle read latency. It issues one read per cycle. Each returned word is compared with the captured key in the cycle after its read was issued, while the next read address is already on the bus.

Because fetch and compare overlap, a hit is seen while the address register already points one word past the match. The unit spends one extra cycle correcting the address by one word size. It then presents the byte address of the first matching word with a one-cycle done strobe. While the scan runs, the unit holds a stall output to freeze upstream instruction flow. It also flags a bubble toward writeback.

Top module: `mem_search_unit`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, stall_o, bubble_o, mem_req_o and done_o are all 0.
- R2: A start_i sampled high while idle captures key_i and base_addr_i. In the next cycle the unit issues a read (mem_req_o=1) at exactly base_addr_i.
- R3: Each later read cycle of the same search requests the previous read address plus 4, and addresses wrap modulo 2^32.
- R4: In each search cycle after the first read, mem_rdata_i (the word returned for the previous request) is compared with the captured key. Changes on key_i and base_addr_i after the start is accepted have no effect.
- R5: stall_o and bubble_o are 1 in every cycle from the first read up to and including the cycle in which the hit is seen, and 0 otherwise.
- R6: done_o is 1 for exactly one cycle, the cycle after the hit, and stall_o is 0 in that cycle.
- R7: When done_o is 1, result_o equals the last read address minus 4, which is the byte address of the first matching word at or after the start address.
- R8: start_i is ignored while a search is in progress, including the done cycle. A new search can start only in a cycle where stall_o and done_o are both 0.
- R9: When the first word read matches, done_o rises in the third cycle after the start is sampled, with result_o equal to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (one-cycle pulse) |
| key_i | input | DATA_W | Word to look for |
| base_addr_i | input | ADDR_W | Word-aligned byte address of the first word |
| mem_req_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory read byte address |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the request |
| stall_o | output | 1 | Freeze fetch and decode |
| bubble_o | output | 1 | Insert a no-op toward writeback |
| done_o | output | 1 | Result valid strobe, one cycle |
| result_o | output | ADDR_W | Byte address of the matching word |

## Verification
The search is run with a hit on the very first word, which shows whether the one-word correction and the minimum latency are both right. It is also run with a hit several words in, which exposes off-by-one errors in the address step. A further case places the key twice in memory, so reporting a later copy or overshooting is visible. A last case starts near the top of the address space so that the read address must wrap through zero. During searches the bench toggles start_i, key_i and base_addr_i, including in the done cycle. Any reloading of the captured values or restart of the scan then shows up as a deviation from the reference linear scan.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SEARCH,
    ST_CORRECT
  } msu_state_e;
endpackage

// File: rtl/msu_addr_gen.sv
module msu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] fixed_o
);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(STEP);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (adv_i)  addr_q <= addr_q + StepV;
  end

  assign addr_o  = addr_q;
  // hit is seen one word late
  assign fixed_o = addr_q - StepV;
endmodule

// File: rtl/msu_key_cmp.sv
module msu_key_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= key_i;
  end

  assign hit_o = (word_i == key_q);
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
  import msu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       hit_i,
  output msu_state_e state_o,
  output logic       load_o,
  output logic       adv_o
);
  msu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_FIRST;
      ST_FIRST:   state_d = ST_SEARCH;
      ST_SEARCH:  if (hit_i) state_d = ST_CORRECT;
      ST_CORRECT: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign load_o  = (state_q == ST_IDLE) && start_i;
  // hold address on hit so the correction subtracts a single word
  assign adv_o   = (state_q == ST_FIRST) || ((state_q == ST_SEARCH) && !hit_i);
endmodule

// File: rtl/mem_search_unit.sv
module mem_search_unit
  import msu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              stall_o,
  output logic              bubble_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] result_o
);
  localparam int WordBytes = DATA_W / 8;

  msu_state_e        state;
  logic              load, adv, hit_raw, hit;
  logic [ADDR_W-1:0] addr, fixed;

  msu_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .hit_i   (hit),
    .state_o (state),
    .load_o  (load),
    .adv_o   (adv)
  );

  msu_addr_gen #(.ADDR_W(ADDR_W), .STEP(WordBytes)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (base_addr_i),
    .adv_i       (adv),
    .addr_o      (addr),
    .fixed_o     (fixed)
  );

  msu_key_cmp #(.DATA_W(DATA_W)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .key_i  (key_i),
    .word_i (mem_rdata_i),
    .hit_o  (hit_raw)
  );

  // data is only meaningful once a read has returned
  assign hit       = hit_raw && (state == ST_SEARCH);
  assign mem_req_o = (state == ST_FIRST) || (state == ST_SEARCH);
  assign mem_addr_o = addr;
  assign stall_o   = mem_req_o;
  assign bubble_o  = mem_req_o;
  assign done_o    = (state == ST_CORRECT);
  assign result_o  = done_o ? fixed : '0;
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              stall_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] result_o
);
  localparam logic [ADDR_W-1:0] StepV = ADDR_W'(DATA_W / 8);

  // R2
  first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stall_o && !done_o) |=> (mem_req_o && mem_addr_o == $past(base_addr_i)));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + StepV));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!stall_o && $past(mem_req_o)));

  // R7
  result_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == $past(mem_addr_o) - StepV));

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);
endmodule

bind mem_search_unit msu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_msu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .base_addr_i (base_addr_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .stall_o     (stall_o),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/test_mem_search_unit.sv
`timescale 1ns/1ps
module test_mem_search_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] key_i = '0, base_addr_i = '0, mem_rdata_i = '0;
  logic        mem_req_o, stall_o, bubble_o, done_o;
  logic [31:0] mem_addr_o, result_o;

  int errors = 0, checks = 0;
  logic [31:0] mem [64];

  always #2 clk_i = ~clk_i;

  mem_search_unit i_mem_search_unit (.*);

  // synchronous memory, one-cycle latency, 64-word image aliased over the space
  always_ff @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o[7:2]];

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ref_scan(logic [31:0] base, logic [31:0] key);
    for (int k = 0; k < 64; k++)
      if (mem[(base[7:2] + k) % 64] == key) return k;
    return -1;
  endfunction

  // compare every cycle against expected trace from a linear scan
  task automatic run_search(logic [31:0] base, logic [31:0] key, string tag, bit poke);
    int k;
    k = ref_scan(base, key);
    @(negedge clk_i);
    start_i = 1'b1; base_addr_i = base; key_i = key;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int j = 1; j <= k + 3; j++) begin
      if (j <= k + 2) begin
        chk({tag, " R5 stall"}, {31'd0, stall_o}, 32'd1);
        chk({tag, " R5 bubble"}, {31'd0, bubble_o}, 32'd1);
        chk({tag, " R2/R3 addr"}, mem_req_o ? mem_addr_o : 32'hdead, base + 32'(4 * (j - 1)));
        chk({tag, " R6 no early done"}, {31'd0, done_o}, 32'd0);
      end else begin
        chk({tag, " R6 done"}, {31'd0, done_o}, 32'd1);
        chk({tag, " R6 stall low"}, {31'd0, stall_o}, 32'd0);
        chk({tag, " R7 result"}, result_o, base + 32'(4 * k));
      end
      if (poke && (j == 2 || j == k + 3)) begin
        // R4 R8: disturbances that must be ignored
        start_i = 1'b1; key_i = ~key; base_addr_i = base + 32'h40;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk({tag, " R8 idle after done"}, {29'd0, mem_req_o, stall_o, done_o}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0103);
    #1;
    chk("R1 in reset", {28'd0, stall_o, bubble_o, mem_req_o, done_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {28'd0, stall_o, bubble_o, mem_req_o, done_o}, 32'd0);

    // R9: hit on the first word
    run_search(32'h0000_0010, mem[4], "R9 first", 1'b0);
    // hit several words in
    run_search(32'h0000_0020, mem[13], "mid", 1'b0);
    // R4 R8: disturb inputs mid-search and in done cycle
    run_search(32'h0000_0004, mem[9], "poke", 1'b1);
    // R7: duplicate key, first copy wins
    mem[20] = 32'h1234_5678; mem[25] = 32'h1234_5678;
    run_search(32'h0000_0028, 32'h1234_5678, "R7 dup", 1'b0);
    // R3: address wraps through zero
    run_search(32'hFFFF_FFF0, mem[2], "R3 wrap", 1'b1);
    // R9 again after idle, first word with disturbance
    run_search(32'h0000_0080, mem[32], "R9 again", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule